// File: doc/BRIEF.md
# CAN Error Status and Counter Registers

This block holds the error reporting registers of a CAN controller. It sits between the protocol engine and a simple CPU register bus. The protocol engine sends it one-cycle error pulses for six kinds of frame error. It also sends counter events (receive error, good reception, transmit error, good transmission), live line status and a wake event. The block keeps sticky error flags until software reads them. It also keeps three write-one-to-clear interrupt flags and the receive and transmit error counters, and from the counters it derives the fault-confinement state.

The CPU side is a plain register port. A cycle with `bus_cs` high and `bus_we` low is a read. Its data is registered and appears one cycle later, with `bus_rvalid` high for that one cycle. A cycle with `bus_cs` and `bus_we` both high is a write. The port never stalls, so it has no back-pressure. Word address 0 selects the status register and word address 1 selects the counter register. Any other address reads as zero.

Bus-off is held until reset, because recovery is left to the surrounding controller.

Top module: `can_err_status_unit`

## Requirements
- R1: After reset, both registers read as zero and all three interrupt outputs are low.
- R2: Each pulse on `err_evt[5:0]` sets a status bit: bit 5 (bit-1 error) sets bit 15, bit 4 (bit-0) sets bit 14, bit 3 (ack) sets bit 13, bit 2 (CRC) sets bit 12, bit 1 (form) sets bit 11 and bit 0 (stuff) sets bit 10. A set bit stays set until the status register is read.
- R3: A status read returns the bits as they were before the read, then clears bits 15:10. An error pulse in the same cycle as the read stays set for the next read.
- R4: Status bit 9 is 1 when the transmit count is 96 or more, and bit 8 is 1 when the receive count is 96 or more. Bit 7 mirrors `bus_idle` and bit 6 mirrors `tx_mode`. Bit 3 and bits 31:16 read as zero.
- R5: Status bits 5:4 give the fault-confinement state: 00 is error-active, 01 is error-passive (either count 128 or more), and 10 is bus-off.
- R6: Status bits 2 (bus-off), 1 (error) and 0 (wake) are interrupt flags, and they are the only writable bits. Writing 1 to one of them clears it and writing 0 leaves it alone. If a set event and a clear arrive in the same cycle, the set wins. Writes to the counter register have no effect.
- R7: Any error pulse sets the error flag, `wake_evt` sets the wake flag, and entering bus-off sets the bus-off flag. `irq_err`, `irq_wake` and `irq_boff` each follow their flag.
- R8: The counter register holds the receive count in bits 15:8 and the transmit count in bits 7:0. Bits 31:16 read as zero.
- R9: `rx_err` adds 1 to the receive count while it is 127 or less. Once the count is above 127, further receive errors leave it unchanged. If `rx_err` and `rx_ok` arrive together, `rx_err` takes effect.
- R10: `rx_ok` reloads the receive count to 119 when it is above 127. Otherwise it subtracts 1 when the count is nonzero.
- R11: `tx_err` adds 8 to the transmit count, and `tx_ok` subtracts 1 when the count is nonzero, with `tx_err` taking effect if both arrive together. A `tx_err` that would bring the count to 256 or more enters bus-off instead and leaves the count at 255. In bus-off both counters stay frozen until reset.
- R12: Read data appears one cycle after the read cycle, with `bus_rvalid` high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (0 status, 1 counters) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| err_evt | input | 6 | Error pulses: bit-1, bit-0, ack, CRC, form, stuff (bits 5..0) |
| rx_err | input | 1 | Receive error event |
| rx_ok | input | 1 | Successful reception event |
| tx_err | input | 1 | Transmit error event |
| tx_ok | input | 1 | Successful transmission event |
| bus_idle | input | 1 | Live bus idle status |
| tx_mode | input | 1 | Live direction status (1 = transmitting) |
| wake_evt | input | 1 | Wake-up event |
| irq_boff | output | 1 | Bus-off interrupt request |
| irq_err | output | 1 | Error interrupt request |
| irq_wake | output | 1 | Wake interrupt request |

## Verification
A wrong counter value shows at the next counter read. Once it drifts across 96, 128 or 256, it also shows at the next status read as a wrong warning bit or a wrong confinement code. A bus-off entered at the wrong moment raises `irq_boff` in the very next cycle. A sticky error bit lost or kept too long shows at the next status read. A flag that mishandles set against clear shows on its interrupt pin one cycle after the write.

// File: rtl/can_esr_pkg.sv
package can_esr_pkg;
  localparam int NUM_ERR  = 6;
  localparam int NUM_IRQ  = 3;
  // status register bit positions (software decodes these)
  localparam int ERR_LSB  = 10;
  localparam int TXW_BIT  = 9;
  localparam int RXW_BIT  = 8;
  localparam int IDLE_BIT = 7;
  localparam int DIR_BIT  = 6;
  localparam int FC_LSB   = 4;
  // interrupt flag indices, equal to their status bit positions
  localparam int IRQ_WAK  = 0;
  localparam int IRQ_ERR  = 1;
  localparam int IRQ_BOFF = 2;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;
endpackage

// File: rtl/can_err_counters.sv
module can_err_counters
  import can_esr_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int RELOAD   = 119,
  parameter int TX_STEP  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             tx_err,
  input  logic             tx_ok,
  output logic [CNT_W-1:0] rx_cnt,
  output logic [CNT_W-1:0] tx_cnt,
  output logic             rx_warn,
  output logic             tx_warn,
  output fc_state_e        fc_state,
  output logic             boff_enter
);
  localparam logic [CNT_W-1:0] WARN_V   = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_V   = CNT_W'(PASS_LIM);
  localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);
  localparam logic [CNT_W:0]   STEP_V   = (CNT_W+1)'(TX_STEP);
  localparam logic [CNT_W-1:0] MAX_V    = {CNT_W{1'b1}};

  logic [CNT_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic             boff_q, boff_d;
  logic [CNT_W:0]   tx_sum;
  logic             rx_sat;

  assign tx_sum = {1'b0, tx_q} + STEP_V;
  assign rx_sat = (rx_q >= PASS_V);

  always_comb begin
    rx_d   = rx_q;
    tx_d   = tx_q;
    boff_d = boff_q;
    if (!boff_q) begin
      if (rx_err) begin
        if (!rx_sat) rx_d = rx_q + 1'b1;
      end else if (rx_ok) begin
        if (rx_sat)          rx_d = RELOAD_V;
        else if (rx_q != '0) rx_d = rx_q - 1'b1;
      end
      if (tx_err) begin
        if (tx_sum[CNT_W]) begin
          boff_d = 1'b1;
          tx_d   = MAX_V;
        end else begin
          tx_d = tx_sum[CNT_W-1:0];
        end
      end else if (tx_ok && tx_q != '0) begin
        tx_d = tx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      tx_q   <= '0;
      boff_q <= 1'b0;
    end else begin
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      boff_q <= boff_d;
    end
  end

  assign boff_enter = boff_d && !boff_q;
  assign rx_cnt     = rx_q;
  assign tx_cnt     = tx_q;
  assign rx_warn    = (rx_q >= WARN_V);
  assign tx_warn    = (tx_q >= WARN_V);

  always_comb begin
    if (boff_q)                             fc_state = FC_BUSOFF;
    else if (rx_q >= PASS_V || tx_q >= PASS_V) fc_state = FC_PASSIVE;
    else                                    fc_state = FC_ACTIVE;
  end

  // R9: a saturated receive count ignores receive errors
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_q >= PASS_V && rx_err) |=> $stable(rx_q));
  // R10: good reception after saturation reloads the count
  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!boff_q && rx_q >= PASS_V && rx_ok && !rx_err) |=> (rx_q == RELOAD_V));
  // R11: transmit errors below the limit step by the increment
  a_r11_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!boff_q && tx_err && !tx_sum[CNT_W]) |=> (tx_q == $past(tx_q) + CNT_W'(TX_STEP)));
  // R11: bus-off is held with frozen counters
  a_r11_boff_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    boff_q |=> (boff_q && $stable(tx_q) && $stable(rx_q)));
endmodule

// File: rtl/can_err_flags.sv
module can_err_flags
  import can_esr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] err_evt,
  input  logic               rd_clr,
  input  logic [NUM_IRQ-1:0] clr_mask,
  input  logic               boff_set,
  input  logic               wake_evt,
  output logic [NUM_ERR-1:0] err_lat,
  output logic [NUM_IRQ-1:0] irq_flag
);
  logic [NUM_ERR-1:0] lat_q;
  logic [NUM_IRQ-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= (rd_clr ? '0 : lat_q) | err_evt;
  end
  assign err_lat = lat_q;

  always_comb begin
    set_vec           = '0;
    set_vec[IRQ_WAK]  = wake_evt;
    set_vec[IRQ_ERR]  = |err_evt;
    set_vec[IRQ_BOFF] = boff_set;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          f_q <= 1'b0;
      else if (set_vec[i]) f_q <= 1'b1;
      else if (clr_mask[i]) f_q <= 1'b0;
    end
    assign irq_flag[i] = f_q;

    // R6: write-one clears a flag when no set competes
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !set_vec[i]) |=> !irq_flag[i]);
    // R7: a set event always leaves the flag high
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> irq_flag[i]);
  end

  // R3: a read with no new error empties the latch
  a_r3_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && err_evt == '0) |=> (err_lat == '0));
  // R2: without a read, latched bits never drop
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((err_lat & $past(err_lat)) == $past(err_lat)));
endmodule

// File: rtl/can_err_status_unit.sv
module can_err_status_unit
  import can_esr_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int RELOAD   = 119,
  parameter int TX_STEP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [5:0]        err_evt,
  input  logic              rx_err,
  input  logic              rx_ok,
  input  logic              tx_err,
  input  logic              tx_ok,
  input  logic              bus_idle,
  input  logic              tx_mode,
  input  logic              wake_evt,
  output logic              irq_boff,
  output logic              irq_err,
  output logic              irq_wake
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CNT_ADDR  = ADDR_W'(1);

  logic             rd_hit, wr_stat, rd_stat;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic             rx_warn, tx_warn, boff_enter;
  fc_state_e        fc_state;
  logic [NUM_ERR-1:0] err_lat;
  logic [NUM_IRQ-1:0] irq_flag, clr_mask;
  logic [DATA_W-1:0]  stat_word, cnt_word, rd_mux, rdata_q;
  logic               rvalid_q;

  assign rd_hit  = bus_cs && !bus_we;
  assign rd_stat = rd_hit && (bus_addr == STAT_ADDR);
  assign wr_stat = bus_cs && bus_we && (bus_addr == STAT_ADDR);
  assign clr_mask = wr_stat ? bus_wdata[NUM_IRQ-1:0] : '0;

  can_err_counters #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM),
    .RELOAD(RELOAD), .TX_STEP(TX_STEP)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .rx_err(rx_err), .rx_ok(rx_ok), .tx_err(tx_err), .tx_ok(tx_ok),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_warn(rx_warn), .tx_warn(tx_warn),
    .fc_state(fc_state), .boff_enter(boff_enter)
  );

  can_err_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .err_evt(err_evt), .rd_clr(rd_stat), .clr_mask(clr_mask),
    .boff_set(boff_enter), .wake_evt(wake_evt),
    .err_lat(err_lat), .irq_flag(irq_flag)
  );

  always_comb begin
    stat_word = '0;
    stat_word[ERR_LSB +: NUM_ERR] = err_lat;
    stat_word[TXW_BIT]            = tx_warn;
    stat_word[RXW_BIT]            = rx_warn;
    stat_word[IDLE_BIT]           = bus_idle;
    stat_word[DIR_BIT]            = tx_mode;
    stat_word[FC_LSB +: 2]        = fc_state;
    stat_word[NUM_IRQ-1:0]        = irq_flag;
  end

  always_comb begin
    cnt_word = '0;
    cnt_word[CNT_W +: CNT_W] = rx_cnt;
    cnt_word[0 +: CNT_W]     = tx_cnt;
  end

  always_comb begin
    if (bus_addr == STAT_ADDR)     rd_mux = stat_word;
    else if (bus_addr == CNT_ADDR) rd_mux = cnt_word;
    else                           rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_hit;
      if (rd_hit) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign irq_boff   = irq_flag[IRQ_BOFF];
  assign irq_err    = irq_flag[IRQ_ERR];
  assign irq_wake   = irq_flag[IRQ_WAK];

  // R12: every read cycle yields one valid cycle next
  a_r12_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> bus_rvalid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> !bus_rvalid);
  // R8: upper half of any returned word is zero
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> (bus_rdata[DATA_W-1:16] == '0));
endmodule

// File: tb/test_can_err_status_unit.sv
`timescale 1ns/1ps
module test_can_err_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 0, bus_we = 0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [5:0]  err_evt = '0;
  logic        rx_err = 0, rx_ok = 0, tx_err = 0, tx_ok = 0;
  logic        bus_idle = 0, tx_mode = 0, wake_evt = 0;
  logic        irq_boff, irq_err, irq_wake;

  int vectors = 0;
  int fails   = 0;

  // bench model state
  logic [5:0] m_lat;
  logic       m_boff, m_erri, m_wak, m_off;
  int         m_rx, m_tx;

  always #4 clk = ~clk;

  can_err_status_unit i_can_err_status_unit (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .err_evt(err_evt), .rx_err(rx_err),
    .rx_ok(rx_ok), .tx_err(tx_err), .tx_ok(tx_ok), .bus_idle(bus_idle),
    .tx_mode(tx_mode), .wake_evt(wake_evt), .irq_boff(irq_boff),
    .irq_err(irq_err), .irq_wake(irq_wake)
  );

  function automatic logic [31:0] exp_stat(input logic idle, input logic dir);
    logic [1:0] fc;
    if (m_off)                       fc = 2'b10;
    else if (m_rx >= 128 || m_tx >= 128) fc = 2'b01;
    else                             fc = 2'b00;
    return {16'h0, m_lat, (m_tx >= 96), (m_rx >= 96), idle, dir, fc,
            1'b0, m_boff, m_erri, m_wak};
  endfunction

  function automatic logic [31:0] exp_cnt();
    return {16'h0, m_rx[7:0], m_tx[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lat = '0; m_boff = 0; m_erri = 0; m_wak = 0; m_off = 0;
    m_rx = 0; m_tx = 0;
  endtask

  // one cycle: drive at negedge, update model at posedge, check at next negedge
  task automatic step(input logic cs, input logic we, input logic [1:0] addr,
                      input logic [31:0] wd, input logic [5:0] evt,
                      input logic rxe, input logic rxo, input logic txe,
                      input logic txo, input logic idle, input logic dir,
                      input logic wk, input string tag);
    logic [31:0] exp_rd;
    logic        rd, bo_enter;
    bus_cs = cs; bus_we = we; bus_addr = addr; bus_wdata = wd;
    err_evt = evt; rx_err = rxe; rx_ok = rxo; tx_err = txe; tx_ok = txo;
    bus_idle = idle; tx_mode = dir; wake_evt = wk;
    rd = cs && !we;
    exp_rd = (addr == 2'd0) ? exp_stat(idle, dir) :
             (addr == 2'd1) ? exp_cnt() : 32'h0;
    @(posedge clk);
    // model update from pre-edge state
    bo_enter = 0;
    if (!m_off) begin
      if (rxe) begin
        if (m_rx < 128) m_rx++;
      end else if (rxo) begin
        if (m_rx >= 128)   m_rx = 119;
        else if (m_rx > 0) m_rx--;
      end
      if (txe) begin
        if (m_tx + 8 >= 256) begin m_off = 1; m_tx = 255; bo_enter = 1; end
        else m_tx += 8;
      end else if (txo && m_tx > 0) m_tx--;
    end
    m_lat = ((rd && addr == 2'd0) ? 6'h0 : m_lat) | evt;
    if (cs && we && addr == 2'd0) begin
      if (wd[2]) m_boff = 0;
      if (wd[1]) m_erri = 0;
      if (wd[0]) m_wak  = 0;
    end
    if (bo_enter) m_boff = 1;
    if (|evt)     m_erri = 1;
    if (wk)       m_wak  = 1;
    @(negedge clk);
    chk({tag, " R7 irq"}, {29'h0, irq_boff, irq_err, irq_wake},
        {29'h0, m_boff, m_erri, m_wak});
    chk({tag, " R12 rvalid"}, {31'h0, bus_rvalid}, {31'h0, rd});
    if (rd) chk({tag, " rdata"}, bus_rdata, exp_rd);
    bus_cs = 0; bus_we = 0; err_evt = '0; rx_err = 0; rx_ok = 0;
    tx_err = 0; tx_ok = 0; wake_evt = 0;
  endtask

  task automatic idle_cyc(input string tag);
    step(0, 0, 2'd0, 32'h0, 6'h0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rd_reg(input logic [1:0] a, input string tag);
    step(1, 0, a, 32'h0, 6'h0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr_stat(input logic [31:0] d, input string tag);
    step(1, 1, 2'd0, d, 6'h0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic random_phase(input int n, input int rxw, input int txw);
    for (int k = 0; k < n; k++) begin
      logic cs, we;
      logic [1:0] a;
      logic [5:0] ev;
      cs = ($urandom % 3) == 0;
      we = ($urandom % 3) == 0;
      a  = 2'($urandom % 3);
      ev = (($urandom % 6) == 0) ? 6'($urandom) : 6'h0;
      step(cs, we, a, $urandom, ev,
           ($urandom % 100) < rxw, ($urandom % 100) < 30,
           ($urandom % 100) < txw, ($urandom % 100) < 30,
           1'($urandom), 1'($urandom), ($urandom % 20) == 0, "RND");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    do_reset();
    // R1: reset contents
    rd_reg(2'd0, "R1 stat");
    rd_reg(2'd1, "R1 cnt");
    rd_reg(2'd2, "R8 unmapped");
    // R2: latch bit-1 and stuff errors, sticky over idle cycles
    step(0, 0, 2'd0, 0, 6'b100001, 0, 0, 0, 0, 0, 0, 0, "R2 pulse");
    idle_cyc("R2 hold");
    step(1, 0, 2'd0, 0, 6'h0, 0, 0, 0, 0, 1, 1, 0, "R2 R4 read");
    rd_reg(2'd0, "R3 cleared");
    // R3: pulse coincident with read survives
    step(0, 0, 2'd0, 0, 6'b001000, 0, 0, 0, 0, 0, 0, 0, "R3 pre");
    step(1, 0, 2'd0, 0, 6'b010000, 0, 0, 0, 0, 0, 0, 0, "R3 same");
    rd_reg(2'd0, "R3 survives");
    // R6: zero write no effect, w1c, counter write ignored, set wins
    step(0, 0, 2'd0, 0, 6'h0, 0, 0, 0, 0, 0, 0, 1, "R7 wake");
    wr_stat(32'hFFFF_FFF8, "R6 zero");
    rd_reg(2'd0, "R6 after zero");
    step(1, 1, 2'd1, 32'hFFFF_FFFF, 6'h0, 0, 0, 0, 0, 0, 0, 0, "R6 cntwr");
    rd_reg(2'd1, "R6 cnt unchanged");
    step(1, 1, 2'd0, 32'h2, 6'h04, 0, 0, 0, 0, 0, 0, 0, "R6 setwins");
    wr_stat(32'h3, "R6 clear");
    rd_reg(2'd0, "R6 cleared");
    // R9/R10: receive saturation and reload
    for (int k = 0; k < 130; k++)
      step(0, 0, 2'd0, 0, 6'h0, 1, 0, 0, 0, 0, 0, 0, "R9 inc");
    rd_reg(2'd1, "R9 sat");
    rd_reg(2'd0, "R5 passive");
    step(0, 0, 2'd0, 0, 6'h0, 1, 1, 0, 0, 0, 0, 0, "R9 both");
    rd_reg(2'd1, "R9 both");
    step(0, 0, 2'd0, 0, 6'h0, 0, 1, 0, 0, 0, 0, 0, "R10 reload");
    rd_reg(2'd1, "R10 119");
    step(0, 0, 2'd0, 0, 6'h0, 0, 1, 0, 0, 0, 0, 0, "R10 dec");
    rd_reg(2'd1, "R10 118");
    rd_reg(2'd0, "R4 rxwarn");
    // R11: transmit to bus-off
    for (int k = 0; k < 31; k++)
      step(0, 0, 2'd0, 0, 6'h0, 0, 0, 1, 0, 0, 0, 0, "R11 inc");
    rd_reg(2'd1, "R11 248");
    step(0, 0, 2'd0, 0, 6'h0, 0, 0, 0, 1, 0, 0, 0, "R11 dec");
    step(0, 0, 2'd0, 0, 6'h0, 0, 0, 1, 0, 0, 0, 0, "R11 255");
    rd_reg(2'd1, "R11 255");
    step(0, 0, 2'd0, 0, 6'h0, 0, 0, 1, 0, 0, 0, 0, "R11 boff");
    rd_reg(2'd0, "R5 busoff");
    step(0, 0, 2'd0, 0, 6'h0, 1, 1, 1, 1, 0, 0, 0, "R11 frozen");
    rd_reg(2'd1, "R11 frozen");
    wr_stat(32'h4, "R6 boff clr");
    rd_reg(2'd0, "R6 boff clr");
    // random phases
    do_reset();
    rd_reg(2'd0, "R1 again");
    random_phase(3000, 20, 5);
    do_reset();
    random_phase(3000, 40, 15);
    do_reset();
    random_phase(2000, 10, 30);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule